// File: doc/BRIEF.md
# Pipelined Eight-Key Ascending Sorter

This block sorts a batch of eight unsigned keys into ascending order. The whole batch arrives in parallel on one wide input bus, marked by a valid flag. The sorted batch leaves on an equally wide output bus with its own valid flag, a fixed six cycles later. The sort is done by nineteen compare-and-swap cells arranged as an odd-even merge network of six layers. Each cell puts the smaller of its two keys on its lower lane and the larger on its upper lane. Within a layer every cell works on its own pair of lanes, and all cells of a layer work at the same time.

A register bank follows every layer, so a new batch may enter on every clock. Lanes that a layer does not touch are registered as well, so every key sees the same latency. A valid bit travels beside the keys through all six banks. The interface is valid-only and has no back-pressure. Every cycle in which `in_valid` is high is accepted. The consumer must take each result in the cycle in which `out_valid` is high, because the block holds no result beyond that cycle. Key data registers are not reset. Only the valid chain is cleared, by a synchronous active-high reset.

Top module: `sort8_pipe`

## Requirements
- R1: When `out_valid` is high, `out_keys` is in ascending order by lane. Lane i occupies bits [32*i+31 : 32*i] of both key buses, lane 0 holds the smallest key and lane 7 the largest.
- R2: The output batch is a permutation of the input batch: duplicates are all kept, and equal keys pass through without any change of value.
- R3: Keys are compared as unsigned 32-bit numbers, so a key with bit 31 set orders above every key with bit 31 clear.
- R4: A batch presented with `in_valid` high at a rising edge appears sorted on `out_keys`, with `out_valid` high, after the sixth rising edge that follows it. The output is exactly six cycles later.
- R5: Batches presented on consecutive cycles each come out sorted on consecutive cycles, in the order they entered, without affecting one another.
- R6: A cycle with `in_valid` low produces a cycle with `out_valid` low six cycles later, whatever keys are on `in_keys`. Gaps in the input stream are kept in the output stream.
- R7: While `rst` is high at a rising edge, `out_valid` is low after that edge. After reset is released, `out_valid` stays low until a valid batch has had time to cross the pipeline.
- R8: A reset asserted while batches are in flight discards them: none of them ever raises `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid chain |
| in_valid | input | 1 | High when `in_keys` carries a batch to sort |
| in_keys | input | 256 | Eight unsigned 32-bit keys, lane i at bits [32*i+31:32*i] |
| out_valid | output | 1 | High when `out_keys` carries a sorted batch |
| out_keys | output | 256 | Sorted keys, lane 0 smallest, same lane layout |

## Verification
The bench uses several kinds of batch, and each one shows a different fault:
- **Already-sorted and fully reversed batches** show cells that swap when they should pass, or that pass when they should swap.
- **All-equal batches and batches with duplicates** show lost or duplicated keys.
- **Keys near the top of the range, mixed with small ones**, show a comparison done as signed rather than unsigned.
- **A long pseudo-random stream with scattered idle cycles** shows wrong layer wiring, crosstalk between neighbouring batches, and valid bits that drift against their data.
- **Reset tests**, one at start-up and one with batches in flight, show whether the valid chain is cleared.

// File: rtl/sort8_pkg.sv
package sort8_pkg;

  localparam int LANES  = 8;
  localparam int LAYERS = 6;

  // Lane paired with `lane` in comparator layer `layer`; a lane paired
  // with itself passes straight through that layer.
  function automatic int mate(input int layer, input int lane);
    int m;
    m = lane;
    case (layer)
      0: m = lane ^ 1;
      1: m = lane ^ 2;
      2: case (lane)
           1: m = 2;
           2: m = 1;
           5: m = 6;
           6: m = 5;
           default: m = lane;
         endcase
      3: m = lane ^ 4;
      4: case (lane)
           2: m = 4;
           4: m = 2;
           3: m = 5;
           5: m = 3;
           default: m = lane;
         endcase
      default: case (lane)
           1: m = 2;
           2: m = 1;
           3: m = 4;
           4: m = 3;
           5: m = 6;
           6: m = 5;
           default: m = lane;
         endcase
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sort8_cas.sv
module sort8_cas #(
  parameter int KEY_W = 32
) (
  input  logic [KEY_W-1:0] a_i,
  input  logic [KEY_W-1:0] b_i,
  output logic [KEY_W-1:0] lo_o,
  output logic [KEY_W-1:0] hi_o
);

  logic swap;

  // Strict comparison: equal keys are left where they are.
  assign swap = (a_i > b_i);
  assign lo_o = swap ? b_i : a_i;
  assign hi_o = swap ? a_i : b_i;

endmodule

// File: rtl/sort8_layer.sv
module sort8_layer
  import sort8_pkg::*;
#(
  parameter int KEY_W = 32,
  parameter int LAYER = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        v_i,
  input  logic [LANES-1:0][KEY_W-1:0] d_i,
  output logic                        v_o,
  output logic [LANES-1:0][KEY_W-1:0] q_o
);

  logic [KEY_W-1:0] nxt [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int P = mate(LAYER, i);
    if (P > i) begin : g_cas
      sort8_cas #(.KEY_W(KEY_W)) u_cas (
        .a_i  (d_i[i]),
        .b_i  (d_i[P]),
        .lo_o (nxt[i]),
        .hi_o (nxt[P])
      );
    end else if (P == i) begin : g_pass
      assign nxt[i] = d_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) q_o[k] <= nxt[k];
  end

endmodule

// File: rtl/sort8_pipe.sv
module sort8_pipe
  import sort8_pkg::*;
#(
  parameter int KEY_W = 32,
  localparam int BUS_W = LANES * KEY_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [BUS_W-1:0] in_keys,
  output logic             out_valid,
  output logic [BUS_W-1:0] out_keys
);

  logic [LANES-1:0][KEY_W-1:0] stg_d [LAYERS+1];
  logic                        stg_v [LAYERS+1];

  assign stg_v[0] = in_valid;

  for (genvar i = 0; i < LANES; i++) begin : g_io
    assign stg_d[0][i]              = in_keys[i*KEY_W +: KEY_W];
    assign out_keys[i*KEY_W +: KEY_W] = stg_d[LAYERS][i];
  end

  for (genvar s = 0; s < LAYERS; s++) begin : g_stage
    sort8_layer #(.KEY_W(KEY_W), .LAYER(s)) u_layer (
      .clk (clk),
      .rst (rst),
      .v_i (stg_v[s]),
      .d_i (stg_d[s]),
      .v_o (stg_v[s+1]),
      .q_o (stg_d[s+1])
    );
  end

  assign out_valid = stg_v[LAYERS];

endmodule

// File: rtl/sort8_checker.sv
module sort8_checker
  import sort8_pkg::*;
#(
  parameter int KEY_W = 32,
  localparam int BUS_W = LANES * KEY_W,
  localparam int SUM_W = KEY_W + 3
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [BUS_W-1:0] in_keys,
  input logic             out_valid,
  input logic [BUS_W-1:0] out_keys
);

  logic [2:0]       warm;
  logic [SUM_W-1:0] in_sum, out_sum;
  logic             ordered;

  always_ff @(posedge clk) begin
    if (rst)            warm <= 3'd0;
    else if (warm < 3'd6) warm <= warm + 3'd1;
  end

  always_comb begin
    in_sum  = '0;
    out_sum = '0;
    ordered = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      in_sum  = in_sum  + SUM_W'(in_keys[i*KEY_W +: KEY_W]);
      out_sum = out_sum + SUM_W'(out_keys[i*KEY_W +: KEY_W]);
    end
    for (int i = 0; i + 1 < LANES; i++)
      if (out_keys[i*KEY_W +: KEY_W] > out_keys[(i+1)*KEY_W +: KEY_W])
        ordered = 1'b0;
  end

  // R1: every valid result is ascending
  p_sorted_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ordered);

  // R2: key total is preserved across the six stages
  p_sum_r2: assert property (@(posedge clk) disable iff (rst)
    (warm == 3'd6 && out_valid) |-> out_sum == $past(in_sum, 6));

  // R4: valid emerges exactly six cycles after entry
  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    (warm == 3'd6) |-> out_valid == $past(in_valid, 6));

  // R7: reset clears the output valid
  p_reset_r7: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

bind sort8_pipe sort8_checker #(.KEY_W(KEY_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_keys   (in_keys),
  .out_valid (out_valid),
  .out_keys  (out_keys)
);

// File: tb/sort8_pipe_bench.sv
module sort8_pipe_bench;

  localparam int W  = 32;
  localparam int N  = 8;
  localparam int BW = N * W;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [BW-1:0] in_keys;
  logic          out_valid;
  logic [BW-1:0] out_keys;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [BW-1:0] bat [64];
  logic          vld [64];
  logic [31:0]   seed = 32'h1234_5678;

  always #4 clk = ~clk;

  sort8_pipe #(.KEY_W(W)) u_sort8_pipe (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_keys (in_keys),
    .out_valid (out_valid), .out_keys (out_keys)
  );

  function automatic logic [BW-1:0] ref_sort(input logic [BW-1:0] x);
    logic [W-1:0] k [N];
    logic [W-1:0] t;
    logic [BW-1:0] r;
    for (int i = 0; i < N; i++) k[i] = x[i*W +: W];
    for (int i = 1; i < N; i++)
      for (int j = i; j > 0; j--)
        if (k[j-1] > k[j]) begin t = k[j]; k[j] = k[j-1]; k[j-1] = t; end
    for (int i = 0; i < N; i++) r[i*W +: W] = k[i];
    return r;
  endfunction

  function automatic logic [BW-1:0] pack8(input logic [W-1:0] a0, a1, a2, a3,
                                          a4, a5, a6, a7);
    return {a7, a6, a5, a4, a3, a2, a1, a0};
  endfunction

  function automatic logic [31:0] lcg(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive bat/vld[0..n-1] one per cycle, then idle; compare each output
  // against the batch presented six negedges earlier.
  task automatic run_seq(input int n, input string tag);
    logic ev;
    for (int c = 0; c < n + 6; c++) begin
      @(negedge clk);
      if (c < n) begin in_valid = vld[c]; in_keys = bat[c]; end
      else       begin in_valid = 1'b0;   in_keys = '0;     end
      ev = (c >= 6) ? vld[c-6] : 1'b0;
      check(out_valid === ev, tag, "out_valid", BW'(out_valid), BW'(ev));
      if (ev)
        check(out_keys === ref_sort(bat[c-6]), tag, "out_keys",
              out_keys, ref_sort(bat[c-6]));
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b1; in_keys = '1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(out_valid === 1'b0, "R7", "valid in reset", BW'(out_valid), '0);
    end
    rst = 1'b0; in_valid = 1'b0;
    for (int c = 0; c < 7; c++) begin
      @(negedge clk);
      check(out_valid === 1'b0, "R7", "valid after reset", BW'(out_valid), '0);
    end
  endtask

  task automatic t_single();
    bat[0] = pack8(7, 6, 5, 4, 3, 2, 1, 0);
    vld[0] = 1'b1;
    run_seq(1, "R4");
  endtask

  task automatic t_patterns();
    bat[0] = pack8(1, 2, 3, 4, 5, 6, 7, 8);
    bat[1] = pack8(32'hFFFF_FFFF, 32'hF000_0000, 32'h8000_0001, 32'h8000_0000,
                   32'h7FFF_FFFF, 32'h10, 32'h1, 32'h0);
    bat[2] = {N{32'hDEAD_BEEF}};
    bat[3] = pack8(9, 3, 9, 3, 0, 9, 0, 3);
    bat[4] = pack8(32'h0, 32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF,
                   32'h1, 32'h8000_0000, 32'h0, 32'h7FFF_FFFF);
    bat[5] = pack8(5, 5, 5, 5, 4, 4, 4, 4);
    for (int i = 0; i < 6; i++) vld[i] = 1'b1;
    run_seq(6, "R1/R2/R3");
    for (int i = 0; i < 6; i++) vld[i] = (i % 2 == 0);
    run_seq(6, "R3/R6");
  endtask

  task automatic t_stream();
    for (int i = 0; i < 48; i++) begin
      for (int j = 0; j < N; j++) begin
        seed = lcg(seed);
        bat[i][j*W +: W] = (i % 5 == 0) ? (seed & 32'h8000_000F) : seed;
      end
      vld[i] = (i % 7 != 3);
    end
    run_seq(48, "R5/R6");
  endtask

  task automatic t_flush();
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_keys  = pack8(c, 8, 7, 6, 5, 4, 3, 2);
    end
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      check(out_valid === 1'b0, "R8", "valid after flush", BW'(out_valid), '0);
    end
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_keys = '0;
    t_reset();
    t_single();
    t_patterns();
    t_stream();
    t_flush();
    t_single();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule